// File: doc/BRIEF.md
# Bit-Serial Augmented CRC Divider

This block performs CRC long division one bit per clock in its plain augmented form. A remainder register of R bits is cleared when a message starts. Each accepted message bit is shifted in at bit 0. The bit that leaves the top of the register decides whether the low R coefficients of the generator are XORed into it. There is no preset value, no bit reflection and no output inversion.

In generate mode, the block appends R zero bits by itself after the marked last bit. It then pulses done and presents the R-bit check value. In check mode, the same division runs over a received string that already ends in its check bits, with no padding. An error flag reports a nonzero final remainder. The flag and the remainder hold until the next start.

Top module: `crc_serial_div`

## Requirements
- R1: A start pulse clears the remainder to all zeros on the next edge, and it also abandons any message in progress. The mode input is sampled on that same edge, with 1 meaning check and 0 meaning generate.
- R2: Each accepted bit (valid high while receiving) updates the remainder as follows. The register shifts left by one and the bit enters at bit 0. If the bit shifted out of the top is 1, the low R generator coefficients (parameter POLY, whose bit 0 must be 1) are XORed into the register.
- R3: In generate mode, the remainder after done equals the division of the message followed by R zero bits. With R=4, POLY=4'b0011 and message 100100011100 sent left bit first, the result is 4'b1100.
- R4: In generate mode the padding takes exactly R clocks after the edge that accepts the last bit. Done is visible R edges after that edge.
- R5: Busy is high from the edge after start until the finish cycle. Valid and data are ignored during padding, and busy and done are never high together.
- R6: Done is high for exactly one cycle. Outside a message, the remainder does not change, and valid pulses while idle have no effect.
- R7: In check mode, no padding occurs and done is visible on the edge that accepts the last bit. The remainder is the plain division of the received string.
- R8: In check mode, the error flag is high after done exactly when the remainder is nonzero. A message with its correct check bits appended gives remainder 0 and no error, while a single flipped bit raises the error. The flag holds until the next start and is low in generate mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a new message, clear remainder |
| chk_mode_i | input | 1 | Mode sampled at start: 1 check, 0 generate |
| bit_i | input | 1 | Serial message bit |
| valid_i | input | 1 | bit_i is valid this cycle |
| last_i | input | 1 | Marks the final message bit (with valid_i) |
| busy_o | output | 1 | Message or padding in progress |
| done_o | output | 1 | One-cycle finish pulse |
| rem_o | output | R | Remainder register |
| err_o | output | 1 | Check mode: nonzero remainder at finish |

## Verification
A wrong feedback tap or a wrong shift position corrupts rem_o on the first bit that shifts a 1 out of the top. That happens within R+1 accepted bits, and every later frame's remainder then differs from the bench's long-division model. A pad counter that is off by one moves done by a cycle and changes the generated value, so it shows up in the first generate frame. A mode or error flag that is not cleared on start shows up in the frame that follows a corrupted check frame.

// File: rtl/crc_div_pkg.sv
// Package: shared state encoding for the serial CRC divider.
// Assumes: nothing beyond IEEE 1800-2017.
package crc_div_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for start
        ST_RECV = 2'd1,   // accepting message bits
        ST_PAD  = 2'd2,   // feeding R zero bits (generate mode)
        ST_FIN  = 2'd3    // one-cycle finish
    } div_state_t;
endpackage

// File: rtl/crc_div_shift.sv
// Module: remainder register with one division step per enabled clock.
// What it does: shifts din_i in at bit 0 and applies the generator feedback
// selected by the bit leaving the top.
// Assumes: POLY holds the low R coefficients, and the top coefficient is implicit.
module crc_div_shift #(
    parameter int          R    = 4,
    parameter logic [R-1:0] POLY = 4'b0011
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic         din_i,
    output logic [R-1:0] rem_o
);
    logic [R-1:0] rem_q;
    logic [R-1:0] rem_nxt;
    logic         top_bit;

    assign top_bit = rem_q[R-1];

    // Per-bit next value: shifted bit XOR gated tap.
    generate
        for (genvar g = 0; g < R; g++) begin : g_bit
            if (g == 0) begin : g_low
                assign rem_nxt[g] = din_i ^ (top_bit & POLY[g]);
            end else begin : g_up
                assign rem_nxt[g] = rem_q[g-1] ^ (top_bit & POLY[g]);
            end
        end
    endgenerate

    // Register update: clear on start, step when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) rem_q <= '0;
        else if (en_i)       rem_q <= rem_nxt;
    end

    assign rem_o = rem_q;

    assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (rem_q == '0));
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !en_i) |=> $stable(rem_q));
endmodule

// File: rtl/crc_div_ctrl.sv
// Module: sequencer for the divider.
// What it does: tracks receive/pad/finish phases, counts R pad steps and
// latches the mode at start.
// Assumes: start_i may arrive at any time and restarts the message.
module crc_div_ctrl
    import crc_div_pkg::*;
#(
    parameter int R = 4,
    localparam int CW = $clog2(R + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       chk_mode_i,
    input  logic       valid_i,
    input  logic       last_i,
    input  logic       bit_i,
    output logic       clr_o,
    output logic       step_o,
    output logic       din_o,
    output logic       chk_o,
    output div_state_t state_o
);
    div_state_t    st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic          chk_q;

    // Next-state decision; start takes priority in every state.
    always_comb begin
        st_d = st_q;
        if (start_i) st_d = ST_RECV;
        else begin
            case (st_q)
                ST_IDLE: st_d = ST_IDLE;
                ST_RECV: if (valid_i && last_i) st_d = chk_q ? ST_FIN : ST_PAD;
                ST_PAD:  if (cnt_q == CW'(1)) st_d = ST_FIN;
                ST_FIN:  st_d = ST_IDLE;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // State, pad counter and mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            chk_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (start_i) begin
                chk_q <= chk_mode_i;
                cnt_q <= '0;
            end else if (st_q == ST_RECV && valid_i && last_i) begin
                cnt_q <= CW'(R);
            end else if (st_q == ST_PAD) begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    assign clr_o   = start_i;
    assign step_o  = !start_i && ((st_q == ST_RECV && valid_i) || st_q == ST_PAD);
    assign din_o   = (st_q == ST_RECV) ? bit_i : 1'b0;
    assign chk_o   = chk_q;
    assign state_o = st_q;

    assert_pad_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PAD) |-> (cnt_q != '0 && cnt_q <= CW'(R)));
    assert_check_no_pad_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_q && !start_i && st_q == ST_RECV) |=> (st_q != ST_PAD));
    assert_fin_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FIN) |=> (st_q != ST_FIN));
endmodule

// File: rtl/crc_serial_div.sv
// Module: top of the bit-serial augmented CRC divider.
// What it does: joins sequencer and remainder register, and derives busy, done
// and the check-mode error flag.
// Assumes: POLY[0] == 1 and R between 1 and 32.
module crc_serial_div
    import crc_div_pkg::*;
#(
    parameter int           R    = 4,
    parameter logic [R-1:0] POLY = 4'b0011
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         chk_mode_i,
    input  logic         bit_i,
    input  logic         valid_i,
    input  logic         last_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [R-1:0] rem_o,
    output logic         err_o
);
    logic       clr, step, din, chk;
    div_state_t st;
    logic       fin_seen_q;

    crc_div_ctrl #(.R(R)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chk_mode_i(chk_mode_i),
        .valid_i(valid_i), .last_i(last_i), .bit_i(bit_i),
        .clr_o(clr), .step_o(step), .din_o(din), .chk_o(chk), .state_o(st)
    );

    crc_div_shift #(.R(R), .POLY(POLY)) i_shift (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .en_i(step), .din_i(din),
        .rem_o(rem_o)
    );

    // Remembers that the current message has finished, until the next start.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i)  fin_seen_q <= 1'b0;
        else if (st == ST_FIN)  fin_seen_q <= 1'b1;
    end

    assign busy_o = (st == ST_RECV) || (st == ST_PAD);
    assign done_o = (st == ST_FIN);
    assign err_o  = chk && (done_o || fin_seen_q) && (rem_o != '0);

    assert_busy_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_err_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !busy_o);
    assert_rem_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(rem_o));
endmodule

// File: tb/test_crc_serial_div.sv
module test_crc_serial_div;
    localparam int           R    = 4;
    localparam logic [R-1:0] POLY = 4'b0011;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_i = 0, chk_mode_i = 0, bit_i = 0, valid_i = 0, last_i = 0;
    logic busy_o, done_o, err_o;
    logic [R-1:0] rem_o;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    crc_serial_div #(.R(R), .POLY(POLY)) i_crc_serial_div (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chk_mode_i(chk_mode_i),
        .bit_i(bit_i), .valid_i(valid_i), .last_i(last_i),
        .busy_o(busy_o), .done_o(done_o), .rem_o(rem_o), .err_o(err_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Long division model: msg sent from bit len-1 down to 0, optional R zeros.
    function automatic logic [R-1:0] model(input logic [63:0] msg, input int len, input bit aug);
        logic [R-1:0] r = '0;
        logic top;
        int total = aug ? len + R : len;
        for (int i = 0; i < total; i++) begin
            logic b = (i < len) ? msg[len-1-i] : 1'b0;
            top = r[R-1];
            r = {r[R-2:0], b};
            if (top) r = r ^ POLY;
        end
        return r;
    endfunction

    task automatic pulse_start(input logic chk);
        start_i = 1; chk_mode_i = chk;
        @(negedge clk);
        start_i = 0; chk_mode_i = 0;
        check("R1 clear", rem_o, '0);
        check("R5 busy after start", busy_o, 1'b1);
    endtask

    // Runs one frame and checks timing, remainder and error flag.
    task automatic run_frame(input logic [63:0] msg, input int len, input logic chk,
                             input bit gaps, input logic exp_err_known, input logic exp_err);
        logic [R-1:0] exp = model(msg, len, !chk);
        pulse_start(chk);
        for (int i = 0; i < len; i++) begin
            if (gaps) begin
                int g = $urandom_range(0, 2);
                for (int k = 0; k < g; k++) begin
                    valid_i = 0; bit_i = $urandom; @(negedge clk);
                end
            end
            valid_i = 1; bit_i = msg[len-1-i]; last_i = (i == len-1);
            @(negedge clk);
        end
        last_i = 0;
        if (!chk) begin
            valid_i = 1;   // garbage during padding must be ignored
            for (int k = 0; k < R-1; k++) begin
                bit_i = $urandom;
                check("R4 no early done", done_o, 1'b0);
                check("R5 busy in pad", busy_o, 1'b1);
                @(negedge clk);
            end
            check("R4 still padding", done_o, 1'b0);
            bit_i = $urandom;
            @(negedge clk);
            valid_i = 0;
        end else begin
            valid_i = 0;
        end
        check(chk ? "R7 done timing" : "R4 done timing", done_o, 1'b1);
        check("R5 not busy at done", busy_o, 1'b0);
        check(chk ? "R7 remainder" : "R3 remainder", rem_o, exp);
        check("R8 err flag", err_o, chk && (exp != '0));
        if (exp_err_known) check("R8 expected err", err_o, exp_err);
        @(negedge clk);
        check("R6 done pulse", done_o, 1'b0);
        check("R6 rem held", rem_o, exp);
        check("R8 err held", err_o, chk && (exp != '0));
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 reset rem", rem_o, '0);
        check("R6 reset done", done_o, 1'b0);
        rst_n = 1;
        @(negedge clk);

        // Directed vector for R3
        run_frame(64'b100100011100, 12, 1'b0, 0, 0, 0);
        check("R3 vector", rem_o, 4'b1100);

        // R6: valid pulses while idle change nothing
        valid_i = 1; bit_i = 1; repeat (5) @(negedge clk); valid_i = 0;
        check("R6 idle ignore", rem_o, 4'b1100);
        check("R6 idle no done", done_o, 1'b0);

        // R8: appended check value gives zero, single flip gives error
        run_frame({52'd0, 12'b100100011100, 4'b1100}, 16, 1'b1, 0, 1, 0);
        run_frame({52'd0, 12'b100100011110, 4'b1100}, 16, 1'b1, 0, 1, 1);

        // R1: restart mid-message
        pulse_start(1'b0);
        valid_i = 1; bit_i = 1; repeat (6) @(negedge clk); valid_i = 0;
        run_frame(64'b1011, 4, 1'b0, 0, 0, 0);

        // R2: one-bit message, and all-ones message
        run_frame(64'b1, 1, 1'b0, 0, 0, 0);
        run_frame(64'hFFFF, 16, 1'b0, 1, 0, 0);

        // Random frames in both modes
        for (int t = 0; t < 30; t++) begin
            int len = $urandom_range(1, 40);
            logic [63:0] m = {$urandom, $urandom};
            logic [R-1:0] c;
            m = m & ((64'd1 << len) - 1);
            if (t % 2 == 0) begin
                run_frame(m, len, 1'b0, 1, 0, 0);
            end else begin
                c = model(m, len, 1'b1);
                if (t % 4 == 1) run_frame((m << R) | 64'(c), len + R, 1'b1, 1, 1, 0);
                else run_frame(((m << R) | 64'(c)) ^ (64'd1 << $urandom_range(0, len + R - 1)),
                               len + R, 1'b1, 1, 1, 1);
            end
        end

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule